// File: doc/BRIEF.md
# Programmable Lookup-Table Logic Array

The block is a small logic fabric that software shapes into custom glue logic. It holds 32 identical elements in four blocks of eight. Each element has a two-input lookup table, a storage flip-flop on the fabric clock, and two operand selectors. One 11-bit configuration word per element sets the function, the operand sources and whether the element's port shows the stored or the live result. All 32 element results are visible on one output bus.

Operands travel over fixed, sparse routing. Operand A comes from an even-numbered element of the same block. Operand B comes from an odd-numbered element of the same block, or from an external source. For elements 0 to 15 that source is a GPIO bit or a software data-in bit. For elements 16 to 31 it is the element sixteen places lower. Every value passed between elements is taken from the source element's flip-flop. Because of this, no configuration can close a combinational loop.

Top module: `pla_fabric`

## Requirements
- R1: While `rst_n` is low, every rising edge of `clk` clears all 32 flip-flops. An element set to registered mode (word bit 0 = 1) then drives 0.
- R2: The lookup result is bit (1 + 2·A + B) of the element's word. Bit 1 gives the result for A=0,B=0, bit 2 for A=0,B=1, bit 3 for A=1,B=0 and bit 4 for A=1,B=1.
- R3: With word bit 0 = 1, the element's port shows the lookup result captured at the previous clock edge. With bit 0 = 0, it shows the current lookup result.
- R4: If word bits [10:9] hold k in 1..3, operand A is the stored value of element 2k of the same block.
- R5: If word bits [10:9] = 0, operand A is the stored value of element 0 of the same block. The exception is element 0 of a block, which instead reads element 7 of the previous block; block 0 reads element 7 of block 3 (element 31).
- R6: If word bit 5 = 0, operand B is the stored value of element 2j+1 of the same block, where j is word bits [8:7].
- R7: If word bit 5 = 1, element n in 0..15 takes B from `gpio_i[n]` when bit 6 = 0 and from `sw_din_i[n]` when bit 6 = 1.
- R8: If word bit 5 = 1, element n in 16..31 takes B from the stored value of element n−16, and bit 6 has no effect.
- R9: A change on `gpio_i` or `sw_din_i` within a clock period reaches the port of a bypassed element that reads it before the next edge. It does not reach elements 16..31 until that edge has passed.
- R10: Every flip-flop loads its element's lookup result on each edge out of reset, whatever bit 0 holds. Every operand taken from another element is that element's stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous active-low reset of all element flip-flops |
| cfg_i | input | 352 | Configuration words; element n uses bits [11n+10:11n] |
| gpio_i | input | 16 | External inputs for elements 0..15 |
| sw_din_i | input | 16 | Software data-in bits for elements 0..15 |
| elem_o | output | 32 | Element outputs, bit n from element n |

## Verification
The hardest case to reach is one where results must travel between elements over several cycles. Examples are the wrap from element 31 back to element 0, or a value that moves from the GPIO pins through the lower half into the upper half. Such a case only appears when state built up by earlier configurations is still held in the flip-flops. The bench therefore never resets between phases. Each phase forces one routing field and uses pass-through truth tables, so known GPIO patterns move through the stored state along a chosen path. The external inputs are also flipped in the middle of a period, which separates what reaches a port at once from what waits for the next edge.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
// pla_pkg: shared sizes and the per-element configuration word layout.
// Assumes two selector bits per operand, hence four taps per operand
// and eight elements per block.
package pla_pkg;

    localparam int SEL_W     = 2;
    localparam int TAPS      = 1 << SEL_W;
    localparam int BLK_ELEMS = 2 * TAPS;
    localparam int CFG_W     = 2 * SEL_W + 7;

    // Word layout, most significant field first.
    typedef struct packed {
        logic [SEL_W-1:0] a_sel;      // even-tap choice for operand A
        logic [SEL_W-1:0] b_sel;      // odd-tap choice for operand B
        logic             ext_pick;   // external source: 0 first, 1 alternate
        logic             b_from_ext; // operand B: 0 odd tap, 1 external
        logic [3:0]       truth;      // lookup table indexed by {A,B}
        logic             use_reg;    // port shows 1 stored, 0 live result
    } elem_cfg_t;

endpackage

// File: rtl/pla_operand_sel.sv
`timescale 1ns/1ps
// pla_operand_sel: chooses the two lookup operands of one element.
// Assumes the caller has already gathered the candidate taps: TAPS even
// candidates for A, TAPS odd candidates for B, plus two external bits
// (tie both to the same net when the element has only one external source).
module pla_operand_sel
    import pla_pkg::*;
(
    input  logic [TAPS-1:0]  a_cand_i,
    input  logic [TAPS-1:0]  b_cand_i,
    input  logic [SEL_W-1:0] a_sel_i,
    input  logic [SEL_W-1:0] b_sel_i,
    input  logic             from_ext_i,
    input  logic             pick_alt_i,
    input  logic             ext_lo_i,
    input  logic             ext_alt_i,
    output logic             a_o,
    output logic             b_o
);

    logic ext_bit;

    // Picks the external operand source.
    always_comb begin
        ext_bit = pick_alt_i ? ext_alt_i : ext_lo_i;
    end

    // Drives both operands from their selected taps.
    always_comb begin
        a_o = a_cand_i[a_sel_i];
        b_o = from_ext_i ? ext_bit : b_cand_i[b_sel_i];
    end

endmodule

// File: rtl/pla_lut_cell.sv
`timescale 1ns/1ps
// pla_lut_cell: a two-input lookup table with a result flip-flop.
// The flip-flop captures the lookup result on every edge. The port shows
// either the live result or the stored one. Reset is synchronous, active low.
module pla_lut_cell (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] truth_i,
    input  logic       use_reg_i,
    input  logic       a_i,
    input  logic       b_i,
    output logic       lut_o,
    output logic       q_o,
    output logic       out_o
);

    // Evaluates the truth table at index {A,B}.
    always_comb begin
        lut_o = truth_i[{a_i, b_i}];
    end

    // Stores the lookup result each cycle, cleared under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else begin
            q_o <= lut_o;
        end
    end

    // Selects the stored or the live result for the port.
    always_comb begin
        out_o = use_reg_i ? q_o : lut_o;
    end

endmodule

// File: rtl/pla_fabric.sv
`timescale 1ns/1ps
// pla_fabric: array of NUM_BLOCKS blocks of BLK_ELEMS lookup elements.
// Every route between elements reads stored values, so the fabric has no
// combinational loop under any configuration. The lower half of the
// elements take external bits; the upper half reads the element half the
// array below. NUM_BLOCKS must be even.
module pla_fabric
    import pla_pkg::*;
#(
    parameter int NUM_BLOCKS = 4
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [NUM_BLOCKS*BLK_ELEMS*CFG_W-1:0]   cfg_i,
    input  logic [NUM_BLOCKS*BLK_ELEMS/2-1:0]       gpio_i,
    input  logic [NUM_BLOCKS*BLK_ELEMS/2-1:0]       sw_din_i,
    output logic [NUM_BLOCKS*BLK_ELEMS-1:0]         elem_o
);

    localparam int N_ELEM = NUM_BLOCKS * BLK_ELEMS;
    localparam int HALF   = N_ELEM / 2;

    logic [N_ELEM-1:0] state_q;
    logic [N_ELEM-1:0] lut_res;

    for (genvar g = 0; g < N_ELEM; g++) begin : g_elem
        localparam int BLK  = g / BLK_ELEMS;
        localparam int BASE = BLK * BLK_ELEMS;
        localparam int PREV = (BLK + NUM_BLOCKS - 1) % NUM_BLOCKS;
        localparam int FB   = (g == BASE) ? PREV * BLK_ELEMS + BLK_ELEMS - 1 : BASE;

        elem_cfg_t       cfg;
        logic [TAPS-1:0] a_cand;
        logic [TAPS-1:0] b_cand;
        logic            ext_lo;
        logic            ext_alt;
        logic            a_op;
        logic            b_op;

        assign cfg = elem_cfg_t'(cfg_i[g*CFG_W +: CFG_W]);

        for (genvar k = 0; k < TAPS; k++) begin : g_tap
            assign a_cand[k] = state_q[(k == 0) ? FB : BASE + 2*k];
            assign b_cand[k] = state_q[BASE + 2*k + 1];
        end

        if (g < HALF) begin : g_lo
            assign ext_lo  = gpio_i[g];
            assign ext_alt = sw_din_i[g];
        end else begin : g_hi
            assign ext_lo  = state_q[g - HALF];
            assign ext_alt = state_q[g - HALF];
        end

        pla_operand_sel sel_i (
            .a_cand_i   (a_cand),
            .b_cand_i   (b_cand),
            .a_sel_i    (cfg.a_sel),
            .b_sel_i    (cfg.b_sel),
            .from_ext_i (cfg.b_from_ext),
            .pick_alt_i (cfg.ext_pick),
            .ext_lo_i   (ext_lo),
            .ext_alt_i  (ext_alt),
            .a_o        (a_op),
            .b_o        (b_op)
        );

        pla_lut_cell cell_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .truth_i   (cfg.truth),
            .use_reg_i (cfg.use_reg),
            .a_i       (a_op),
            .b_i       (b_op),
            .lut_o     (lut_res[g]),
            .q_o       (state_q[g]),
            .out_o     (elem_o[g])
        );
    end

endmodule

// File: rtl/pla_fabric_chk.sv
`timescale 1ns/1ps
// pla_fabric_chk: temporal checks on pla_fabric, attached with bind.
// Reads the stored-state and lookup-result vectors between the cells.
module pla_fabric_chk
    import pla_pkg::*;
#(
    parameter int NUM_BLOCKS = 4
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic [NUM_BLOCKS*BLK_ELEMS*CFG_W-1:0] cfg_i,
    input logic [NUM_BLOCKS*BLK_ELEMS/2-1:0]     gpio_i,
    input logic [NUM_BLOCKS*BLK_ELEMS/2-1:0]     sw_din_i,
    input logic [NUM_BLOCKS*BLK_ELEMS-1:0]       elem_o,
    input logic [NUM_BLOCKS*BLK_ELEMS-1:0]       state_q,
    input logic [NUM_BLOCKS*BLK_ELEMS-1:0]       lut_res
);

    localparam int N_ELEM = NUM_BLOCKS * BLK_ELEMS;
    localparam int HALF   = N_ELEM / 2;
    localparam int WRAP   = N_ELEM - 1;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_q == '0));

    // R10
    store_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (state_q == $past(lut_res)));

    // R5
    a_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i[0] == 1'b0 && cfg_i[4:1] == 4'b1100 && cfg_i[10:9] == 2'd0)
        |-> (elem_o[0] == state_q[WRAP]));

    for (genvar e = 0; e < N_ELEM; e++) begin : g_chk
        // R3
        reg_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && cfg_i[e*CFG_W] && $stable(cfg_i[e*CFG_W]))
            |-> (elem_o[e] == $past(lut_res[e])));

        if (e < HALF) begin : g_lo
            // R7
            ext_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_i[e*CFG_W +: 6] == 6'b110100)
                |-> (elem_o[e] == (cfg_i[e*CFG_W + 6] ? sw_din_i[e] : gpio_i[e])));
        end else begin : g_hi
            // R8
            ext_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_i[e*CFG_W +: 6] == 6'b110100)
                |-> (elem_o[e] == state_q[e - HALF]));
        end
    end

endmodule

bind pla_fabric pla_fabric_chk #(.NUM_BLOCKS(NUM_BLOCKS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_i    (cfg_i),
    .gpio_i   (gpio_i),
    .sw_din_i (sw_din_i),
    .elem_o   (elem_o),
    .state_q  (state_q),
    .lut_res  (lut_res)
);

// File: tb/pla_fabric_tb_top.sv
`timescale 1ns/1ps
// Bench for pla_fabric: phases of per-cycle fresh configurations, each
// phase forcing one routing field, checked against a reference model
// built from the requirements.
module pla_fabric_tb_top;
    import pla_pkg::*;

    localparam int NB   = 4;
    localparam int NE   = NB * BLK_ELEMS;
    localparam int HALF = NE / 2;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NE*CFG_W-1:0]   cfg_flat;
    logic [HALF-1:0]       gpio = '0;
    logic [HALF-1:0]       din = '0;
    logic [NE-1:0]         elem_o;

    logic [CFG_W-1:0]      cfg_m [NE];
    logic                  q_m   [NE];
    logic                  lut_m [NE];
    int                    total = 0;
    int                    bad = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int e = 0; e < NE; e++) cfg_flat[e*CFG_W +: CFG_W] = cfg_m[e];
    end

    pla_fabric #(.NUM_BLOCKS(NB)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_i    (cfg_flat),
        .gpio_i   (gpio),
        .sw_din_i (din),
        .elem_o   (elem_o)
    );

    // Modes: 0 free, 2 live, 3 stored, 4 A from taps 1..3 (pass A),
    // 5 A from tap 0 (pass A), 6 B from odd taps (pass B), 7 B external (pass B).
    function automatic logic [CFG_W-1:0] mk(int mode);
        logic [CFG_W-1:0] c = CFG_W'($urandom);
        case (mode)
            2: c[0] = 1'b0;
            3: c[0] = 1'b1;
            4: begin c[0] = 1'b0; c[4:1] = 4'b1100; c[10:9] = 2'(1 + $urandom % 3); end
            5: begin c[0] = 1'b0; c[4:1] = 4'b1100; c[10:9] = 2'd0; end
            6: begin c[0] = 1'b0; c[4:1] = 4'b1010; c[5] = 1'b0; end
            7: begin c[0] = 1'b0; c[4:1] = 4'b1010; c[5] = 1'b1; end
            default: ;
        endcase
        return c;
    endfunction

    // Reference lookup results from R2, R4..R8 and R10.
    task automatic eval();
        for (int e = 0; e < NE; e++) begin
            int blk  = e / BLK_ELEMS;
            int base = blk * BLK_ELEMS;
            logic [CFG_W-1:0] c = cfg_m[e];
            int asel = int'(c[10:9]);
            int bsel = int'(c[8:7]);
            int src;
            logic a, b;
            if (asel != 0) src = base + 2 * asel;
            else if (e == base) src = ((blk + NB - 1) % NB) * BLK_ELEMS + BLK_ELEMS - 1;
            else src = base;
            a = q_m[src];
            if (!c[5]) b = q_m[base + 2 * bsel + 1];
            else if (e < HALF) b = c[6] ? din[e] : gpio[e];
            else b = q_m[e - HALF];
            lut_m[e] = c[1 + 2 * int'(a) + int'(b)];
        end
    endtask

    task automatic check_out(string tag);
        for (int e = 0; e < NE; e++) begin
            logic exp = cfg_m[e][0] ? q_m[e] : lut_m[e];
            total++;
            if (elem_o[e] !== exp) begin
                bad++;
                $display("FAIL %s element %0d: actual=%b expected=%b", tag, e, elem_o[e], exp);
            end
        end
    endtask

    // One clock period: check after settling, optionally flip the external
    // inputs mid-period (R9), then advance the model at the edge.
    task automatic cycle(string tag, bit wiggle);
        #1;
        eval();
        check_out(tag);
        if (wiggle) begin
            gpio = ~gpio;
            din  = ~din;
            #1;
            eval();
            check_out("R9");
        end
        @(posedge clk);
        for (int e = 0; e < NE; e++) q_m[e] = rst_n ? lut_m[e] : 1'b0;
        @(negedge clk);
    endtask

    task automatic phase(string tag, int mode, int n, bit wiggle);
        for (int i = 0; i < n; i++) begin
            for (int e = 0; e < NE; e++) cfg_m[e] = mk(mode);
            gpio = HALF'($urandom);
            din  = HALF'($urandom);
            cycle(tag, wiggle);
        end
    endtask

    initial begin
        for (int e = 0; e < NE; e++) begin
            cfg_m[e] = mk(3);
            q_m[e]   = 1'b0;
        end
        @(negedge clk);
        // R1: stored outputs read zero under reset
        phase("R1", 3, 3, 1'b0);
        rst_n = 1'b1;
        // R2: lookup function in live mode
        phase("R2", 2, 40, 1'b0);
        // R3: stored mode shows previous result
        phase("R3", 3, 40, 1'b0);
        // R4: even taps 2, 4, 6
        phase("R4", 4, 20, 1'b0);
        // R5: tap 0 feedback and wrap from previous block
        phase("R5", 5, 20, 1'b0);
        // R6: odd taps
        phase("R6", 6, 20, 1'b0);
        // R7: GPIO or data-in for the lower half
        phase("R7", 7, 20, 1'b0);
        // R8: upper half reads element n-16
        phase("R8", 7, 20, 1'b0);
        // R10 with R9: stored-value routing, mid-period input flips
        phase("R10", 7, 20, 1'b1);
        phase("R10", 0, 100, 1'b1);
        // R1: reset in the middle of a run
        rst_n = 1'b0;
        phase("R1", 0, 3, 1'b0);
        rst_n = 1'b1;
        phase("R10", 0, 100, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        bad++;
        $display("FAIL watchdog (all requirements): actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule